// File: doc/BRIEF.md
# Single-Frame Receive Holding Buffer

This block sits between a receive MAC, which delivers each frame as a byte stream marked with start and end flags, and a DMA-style consumer that pulls bytes out whenever it is ready. It holds at most one frame. A frame is taken in only when the buffer is empty. A frame that arrives while earlier data is still waiting is thrown away whole and counted as lost. A frame longer than the storage is also thrown away and counted as an oversize error.

When a frame has been captured, the block reports a remaining length equal to the frame size plus four. The four extra bytes stand for the CRC field that is passed through to software, and they are emitted as zero bytes after the stored data. The consumer drains through a valid/ready byte handshake. It can take any number of bytes per burst and may pause at any point. The block exposes the remaining length and the read position, and it flags the last byte. The MAC side cannot be stalled. The `in_ready` output only tells the MAC whether the next frame would be kept.

Top module: `frame_hold_buf`

## Requirements
- R1: After reset, `in_ready` is 1, `out_valid` is 0, `out_remain` and `out_pos` are 0, both pulses are 0 and both counters are 0.
- R2: A frame of N bytes (1 ≤ N ≤ `CAP_BYTES`, default 1536) arriving while the buffer is empty is stored. On the cycle after its end beat, `out_remain` is N+4, `out_pos` is 0 and `out_valid` is 1.
- R3: The consumer receives the N stored bytes in arrival order, followed by four 0x00 bytes. Each cycle with `out_valid` and `out_ready` both high lowers `out_remain` by one and raises `out_pos` by one on the next cycle. `out_last` is high exactly while `out_remain` is 1. Without `out_ready`, the data and the length stay where they are.
- R4: A start beat seen while `out_remain` is not 0 rejects its whole frame. `loss_pulse` is high for one cycle, on the cycle after that start beat, and the buffered data and length are unaffected.
- R5: A frame of more than `CAP_BYTES` bytes is not kept. `oversize_pulse` is high for one cycle, on the cycle after its end beat, `out_remain` stays 0, and the next frame is accepted.
- R6: `loss_count` and `oversize_count` rise by one together with their pulse, and each saturates at 0xFFFF.
- R7: `out_valid` is 0 whenever `out_remain` is 0, and `out_ready` then has no effect.
- R8: `in_ready` is 1 exactly when no frame is being captured or skipped and `out_remain` is 0. It returns to 1 on the cycle after the last byte is taken.
- R9: While no frame is in progress, input beats without the start flag are ignored. They store nothing and raise no event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input byte present this cycle |
| in_data | input | 8 | Input byte |
| in_sof | input | 1 | First byte of a frame |
| in_eof | input | 1 | Last byte of a frame |
| in_ready | output | 1 | Buffer empty; next frame will be kept |
| out_valid | output | 1 | Output byte available |
| out_data | output | 8 | Output byte (zero for the four trailing CRC slots) |
| out_last | output | 1 | Current output byte is the final one |
| out_ready | input | 1 | Consumer takes the output byte |
| out_remain | output | 11 | Bytes left to drain |
| out_pos | output | 11 | Read position within the frame |
| loss_pulse | output | 1 | One-cycle pulse: frame dropped, buffer busy |
| oversize_pulse | output | 1 | One-cycle pulse: frame too long, dropped |
| loss_count | output | 16 | Saturating count of lost frames |
| oversize_count | output | 16 | Saturating count of oversize frames |

## Verification
Every result of this block is registered once, so each one is due exactly one clock after the beat that causes it. The committed length and position appear on the cycle after the end beat, a loss pulse on the cycle after the rejected start beat, an oversize pulse on the cycle after the too-long frame ends, and a drain step on the cycle after the handshake. The bench's reference model advances on the same rising edge as the design, using inputs that were driven just after the previous falling edge. All outputs are compared against it at the next falling edge, so every sample lands one edge after its cause.

// File: rtl/fhb_pkg.sv
package fhb_pkg;
    typedef enum logic [1:0] {
        FS_IDLE = 2'd0,
        FS_FILL = 2'd1,
        FS_SKIP = 2'd2
    } fill_state_e;
endpackage

// File: rtl/fhb_store.sv
module fhb_store #(
    parameter int DEPTH  = 1536,
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data
);
    logic [7:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem_q[wr_addr] <= wr_data;
        end
    end

    assign rd_data = mem_q[rd_addr];
endmodule

// File: rtl/fhb_satcnt.sv
module fhb_satcnt #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    output logic [W-1:0] value
);
    logic [W-1:0] value_d, value_q;

    always_comb begin
        value_d = value_q;
        if (inc && (value_q != {W{1'b1}})) begin
            value_d = value_q + W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            value_q <= '0;
        end else begin
            value_q <= value_d;
        end
    end

    assign value = value_q;
endmodule

// File: rtl/fhb_ctrl.sv
module fhb_ctrl
    import fhb_pkg::*;
#(
    parameter int CAP_BYTES = 1536,
    parameter int CRC_BYTES = 4,
    parameter int LEN_W     = $clog2(CAP_BYTES + CRC_BYTES + 1),
    parameter int ADDR_W    = $clog2(CAP_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_sof,
    input  logic              in_eof,
    input  logic              out_ready,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              pad_sel,
    output logic              in_ready,
    output logic              out_valid,
    output logic              out_last,
    output logic [LEN_W-1:0]  out_remain,
    output logic [LEN_W-1:0]  out_pos,
    output logic              loss_evt,
    output logic              ovf_evt,
    output logic              loss_pulse,
    output logic              ovf_pulse
);
    localparam logic [LEN_W-1:0] CAP_L = LEN_W'(CAP_BYTES);
    localparam logic [LEN_W-1:0] CRC_L = LEN_W'(CRC_BYTES);

    typedef struct packed {
        fill_state_e      st;
        logic [LEN_W-1:0] cnt;
        logic             big;
        logic [LEN_W-1:0] size;
        logic [LEN_W-1:0] rem;
        logic [LEN_W-1:0] pos;
        logic             loss;
        logic             ovf;
    } ctrl_t;

    ctrl_t s_d, s_q;
    logic  take;
    logic  over;

    always_comb begin
        s_d      = s_q;
        s_d.loss = 1'b0;
        s_d.ovf  = 1'b0;
        wr_en    = 1'b0;
        wr_addr  = s_q.cnt[ADDR_W-1:0];
        loss_evt = 1'b0;
        ovf_evt  = 1'b0;
        over     = s_q.big || (s_q.cnt >= CAP_L);
        take     = (s_q.rem != '0) && out_ready;

        if (take) begin
            s_d.rem = s_q.rem - LEN_W'(1);
            s_d.pos = s_q.pos + LEN_W'(1);
        end

        case (s_q.st)
            FS_IDLE: begin
                if (in_valid && in_sof) begin
                    if (s_q.rem == '0) begin
                        wr_en   = 1'b1;
                        wr_addr = '0;
                        s_d.big = 1'b0;
                        if (in_eof) begin
                            s_d.size = LEN_W'(1);
                            s_d.rem  = LEN_W'(1) + CRC_L;
                            s_d.pos  = '0;
                        end else begin
                            s_d.cnt = LEN_W'(1);
                            s_d.st  = FS_FILL;
                        end
                    end else begin
                        loss_evt = 1'b1;
                        if (!in_eof) begin
                            s_d.st = FS_SKIP;
                        end
                    end
                end
            end
            FS_FILL: begin
                if (in_valid) begin
                    wr_en = !over;
                    if (over) begin
                        s_d.big = 1'b1;
                    end else begin
                        s_d.cnt = s_q.cnt + LEN_W'(1);
                    end
                    if (in_eof) begin
                        s_d.st = FS_IDLE;
                        if (over) begin
                            ovf_evt = 1'b1;
                        end else begin
                            s_d.size = s_q.cnt + LEN_W'(1);
                            s_d.rem  = s_q.cnt + LEN_W'(1) + CRC_L;
                            s_d.pos  = '0;
                        end
                    end
                end
            end
            FS_SKIP: begin
                if (in_valid && in_eof) begin
                    s_d.st = FS_IDLE;
                end
            end
            default: s_d.st = FS_IDLE;
        endcase

        s_d.loss = loss_evt;
        s_d.ovf  = ovf_evt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '{st: FS_IDLE, cnt: '0, big: 1'b0, size: '0,
                     rem: '0, pos: '0, loss: 1'b0, ovf: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign pad_sel    = (s_q.pos >= s_q.size);
    assign rd_addr    = pad_sel ? '0 : s_q.pos[ADDR_W-1:0];
    assign in_ready   = (s_q.st == FS_IDLE) && (s_q.rem == '0);
    assign out_valid  = (s_q.rem != '0);
    assign out_last   = (s_q.rem == LEN_W'(1));
    assign out_remain = s_q.rem;
    assign out_pos    = s_q.pos;
    assign loss_pulse = s_q.loss;
    assign ovf_pulse  = s_q.ovf;
endmodule

// File: rtl/frame_hold_buf.sv
module frame_hold_buf #(
    parameter int CAP_BYTES = 1536,
    parameter int CRC_BYTES = 4,
    parameter int CNT_W     = 16,
    parameter int LEN_W     = $clog2(CAP_BYTES + CRC_BYTES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [7:0]       in_data,
    input  logic             in_sof,
    input  logic             in_eof,
    output logic             in_ready,
    output logic             out_valid,
    output logic [7:0]       out_data,
    output logic             out_last,
    input  logic             out_ready,
    output logic [LEN_W-1:0] out_remain,
    output logic [LEN_W-1:0] out_pos,
    output logic             loss_pulse,
    output logic             oversize_pulse,
    output logic [CNT_W-1:0] loss_count,
    output logic [CNT_W-1:0] oversize_count
);
    localparam int ADDR_W = $clog2(CAP_BYTES);

    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic [ADDR_W-1:0] rd_addr;
    logic              pad_sel;
    logic [7:0]        rd_data;
    logic              loss_evt;
    logic              ovf_evt;
    logic [1:0]        evt_vec;
    logic [CNT_W-1:0]  cnt_vec [2];

    fhb_ctrl #(
        .CAP_BYTES(CAP_BYTES),
        .CRC_BYTES(CRC_BYTES),
        .LEN_W    (LEN_W),
        .ADDR_W   (ADDR_W)
    ) i_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_sof    (in_sof),
        .in_eof    (in_eof),
        .out_ready (out_ready),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .rd_addr   (rd_addr),
        .pad_sel   (pad_sel),
        .in_ready  (in_ready),
        .out_valid (out_valid),
        .out_last  (out_last),
        .out_remain(out_remain),
        .out_pos   (out_pos),
        .loss_evt  (loss_evt),
        .ovf_evt   (ovf_evt),
        .loss_pulse(loss_pulse),
        .ovf_pulse (oversize_pulse)
    );

    fhb_store #(
        .DEPTH (CAP_BYTES),
        .ADDR_W(ADDR_W)
    ) i_store (
        .clk    (clk),
        .wr_en  (wr_en),
        .wr_addr(wr_addr),
        .wr_data(in_data),
        .rd_addr(rd_addr),
        .rd_data(rd_data)
    );

    assign evt_vec = {ovf_evt, loss_evt};

    for (genvar g = 0; g < 2; g++) begin : g_evcnt
        fhb_satcnt #(.W(CNT_W)) i_cnt (
            .clk  (clk),
            .rst_n(rst_n),
            .inc  (evt_vec[g]),
            .value(cnt_vec[g])
        );
    end

    assign loss_count     = cnt_vec[0];
    assign oversize_count = cnt_vec[1];
    assign out_data       = pad_sel ? 8'h00 : rd_data;
endmodule

// File: rtl/fhb_checker.sv
module fhb_checker #(
    parameter int CAP_BYTES = 1536,
    parameter int CRC_BYTES = 4,
    parameter int CNT_W     = 16,
    parameter int LEN_W     = $clog2(CAP_BYTES + CRC_BYTES + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_ready,
    input logic             out_valid,
    input logic [7:0]       out_data,
    input logic             out_last,
    input logic             out_ready,
    input logic [LEN_W-1:0] out_remain,
    input logic             loss_pulse,
    input logic             oversize_pulse,
    input logic [CNT_W-1:0] loss_count
);
    AST_REMAIN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        out_remain <= LEN_W'(CAP_BYTES + CRC_BYTES)); // R2

    AST_DRAIN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_ready |=> out_remain == $past(out_remain) - LEN_W'(1)); // R3

    AST_LAST_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_ready && out_last |=> !out_valid); // R3

    AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_remain)); // R3

    AST_LOSS_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        loss_pulse |-> out_remain != '0 || $past(out_valid && out_ready)); // R4

    AST_OVF_NO_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        oversize_pulse |-> out_remain == '0); // R5

    AST_LOSS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        loss_pulse && ($past(loss_count) != {CNT_W{1'b1}})
        |-> loss_count == $past(loss_count) + CNT_W'(1)); // R6

    AST_READY_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> !out_valid); // R8
endmodule

bind frame_hold_buf fhb_checker #(
    .CAP_BYTES(CAP_BYTES),
    .CRC_BYTES(CRC_BYTES),
    .CNT_W    (CNT_W),
    .LEN_W    (LEN_W)
) i_fhb_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .in_ready      (in_ready),
    .out_valid     (out_valid),
    .out_data      (out_data),
    .out_last      (out_last),
    .out_ready     (out_ready),
    .out_remain    (out_remain),
    .loss_pulse    (loss_pulse),
    .oversize_pulse(oversize_pulse),
    .loss_count    (loss_count)
);

// File: tb/test_frame_hold_buf.sv
`timescale 1ns/1ps
module test_frame_hold_buf;
    localparam int CAP   = 1536;
    localparam int CRC   = 4;
    localparam int LEN_W = $clog2(CAP + CRC + 1);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             in_valid = 1'b0;
    logic [7:0]       in_data = 8'h00;
    logic             in_sof = 1'b0;
    logic             in_eof = 1'b0;
    logic             in_ready;
    logic             out_valid;
    logic [7:0]       out_data;
    logic             out_last;
    logic             out_ready = 1'b0;
    logic [LEN_W-1:0] out_remain;
    logic [LEN_W-1:0] out_pos;
    logic             loss_pulse;
    logic             oversize_pulse;
    logic [15:0]      loss_count;
    logic [15:0]      oversize_count;

    int checks = 0;
    int errors = 0;
    int rdy_mode = 0;
    bit running = 1'b0;
    bit finished = 1'b0;

    // reference model state
    int       m_st = 0;
    int       m_n = 0;
    byte      m_fill[$];
    byte      m_frame[$];
    int       m_rem = 0;
    int       m_pos = 0;
    bit       m_loss = 0;
    bit       m_ovf = 0;
    int       m_lc = 0;
    int       m_oc = 0;

    always #2.5 clk = ~clk;

    frame_hold_buf i_frame_hold_buf (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_data(in_data), .in_sof(in_sof), .in_eof(in_eof),
        .in_ready(in_ready),
        .out_valid(out_valid), .out_data(out_data), .out_last(out_last),
        .out_ready(out_ready),
        .out_remain(out_remain), .out_pos(out_pos),
        .loss_pulse(loss_pulse), .oversize_pulse(oversize_pulse),
        .loss_count(loss_count), .oversize_count(oversize_count)
    );

    task automatic chk(input bit ok, input string tag, input string nm,
                       input int got, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s got %0d expected %0d at %0t", tag, nm, got, exp, $time);
        end
    endtask

    task automatic commit();
        m_frame = m_fill;
        m_rem   = m_fill.size() + CRC;
        m_pos   = 0;
    endtask

    // model: advances on the same edge as the design
    always @(posedge clk) begin
        if (rst_n) begin
            m_loss = 0;
            m_ovf  = 0;
            if (m_rem != 0 && out_ready) begin
                m_rem--;
                m_pos++;
            end
            if (in_valid) begin
                case (m_st)
                    0: if (in_sof) begin   // R9: beats without start ignored here
                        if (m_rem == 0) begin
                            m_fill = {};
                            m_fill.push_back(in_data);
                            m_n = 1;
                            if (in_eof) commit();
                            else m_st = 1;
                        end else begin
                            m_loss = 1;
                            if (m_lc < 65535) m_lc++;
                            if (!in_eof) m_st = 2;
                        end
                    end
                    1: begin
                        m_n++;
                        if (m_n <= CAP) m_fill.push_back(in_data);
                        if (in_eof) begin
                            m_st = 0;
                            if (m_n > CAP) begin
                                m_ovf = 1;
                                if (m_oc < 65535) m_oc++;
                            end else commit();
                        end
                    end
                    default: if (in_eof) m_st = 0;
                endcase
            end
        end
    end

    // compare every cycle away from the active edge
    always @(negedge clk) begin
        if (running && rst_n) begin
            chk(in_ready == (m_st == 0 && m_rem == 0), "R8", "in_ready", in_ready, (m_st == 0 && m_rem == 0));
            chk(out_valid == (m_rem != 0), "R7", "out_valid", out_valid, (m_rem != 0));
            chk(out_remain == LEN_W'(m_rem), "R2", "out_remain", out_remain, m_rem);
            chk(out_pos == LEN_W'(m_pos), "R3", "out_pos", out_pos, m_pos);
            chk(out_last == (m_rem == 1), "R3", "out_last", out_last, (m_rem == 1));
            if (m_rem != 0) begin
                int e;
                e = (m_pos < m_frame.size()) ? int'(m_frame[m_pos]) & 255 : 0;
                chk(out_data == 8'(e), "R3", "out_data", out_data, e);
            end
            chk(loss_pulse == m_loss, "R4", "loss_pulse", loss_pulse, m_loss);
            chk(oversize_pulse == m_ovf, "R5", "oversize_pulse", oversize_pulse, m_ovf);
            chk(loss_count == 16'(m_lc), "R6", "loss_count", loss_count, m_lc);
            chk(oversize_count == 16'(m_oc), "R6", "oversize_count", oversize_count, m_oc);
        end
    end

    // consumer
    always @(negedge clk) begin
        #1;
        case (rdy_mode)
            0: out_ready = 1'b1;
            1: out_ready = $urandom_range(0, 1) == 1;
            2: out_ready = ~out_ready;
            default: out_ready = 1'b0;
        endcase
    end

    task automatic tick();
        @(negedge clk);
        #1;
    endtask

    task automatic send_frame(input int n, input bit gaps);
        for (int i = 0; i < n; i++) begin
            tick();
            in_valid = 1'b1;
            in_data  = 8'($urandom);
            in_sof   = (i == 0);
            in_eof   = (i == n - 1);
            if (gaps && ($urandom_range(0, 3) == 0)) begin
                tick();
                in_valid = 1'b0;
                in_sof   = 1'b0;
                in_eof   = 1'b0;
            end
        end
        tick();
        in_valid = 1'b0;
        in_sof   = 1'b0;
        in_eof   = 1'b0;
    endtask

    task automatic wait_empty();
        for (int k = 0; k < 5000; k++) begin
            tick();
            if (in_ready) break;
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        rdy_mode = 3;
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(in_ready == 1'b1, "R1", "in_ready", in_ready, 1);
        chk(out_valid == 1'b0, "R1", "out_valid", out_valid, 0);
        chk(out_remain == '0 && out_pos == '0, "R1", "remain/pos", out_remain, 0);
        chk(!loss_pulse && !oversize_pulse, "R1", "pulses", loss_pulse, 0);
        chk(loss_count == 0 && oversize_count == 0, "R1", "counts", loss_count, 0);
        running = 1'b1;

        // R2/R3: short frame, consumer always ready after it lands
        send_frame(5, 1'b0);
        rdy_mode = 0;
        wait_empty();

        // R9: stray beats without start flag
        rdy_mode = 3;
        for (int i = 0; i < 4; i++) begin
            tick();
            in_valid = 1'b1;
            in_data  = 8'(i + 8'hA0);
            in_eof   = (i == 3);
        end
        tick();
        in_valid = 1'b0;
        in_eof   = 1'b0;

        // single-byte frame, alternating ready
        send_frame(1, 1'b0);
        rdy_mode = 2;
        wait_empty();

        // R4: second frame while first is buffered
        rdy_mode = 3;
        send_frame(20, 1'b1);
        send_frame(7, 1'b0);
        rdy_mode = 1;
        wait_empty();

        // R2: exactly full capacity
        rdy_mode = 3;
        send_frame(CAP, 1'b0);
        rdy_mode = 1;
        wait_empty();

        // R5: one byte too many, then a normal frame is accepted again
        rdy_mode = 3;
        send_frame(CAP + 1, 1'b0);
        repeat (3) tick();
        send_frame(9, 1'b1);
        rdy_mode = 0;
        wait_empty();

        // R6: saturate the loss counter with one-beat frames against a full buffer
        rdy_mode = 3;
        send_frame(3, 1'b0);
        tick();
        in_valid = 1'b1;
        in_sof   = 1'b1;
        in_eof   = 1'b1;
        repeat (65540) tick();
        in_valid = 1'b0;
        in_sof   = 1'b0;
        in_eof   = 1'b0;
        tick();
        chk(loss_count == 16'hFFFF, "R6", "loss_count saturated", loss_count, 65535);
        rdy_mode = 0;
        wait_empty();
        repeat (3) tick();
        finish_run();
    end
endmodule